// File: doc/BRIEF.md
# Per-Core Down-Counting Event Timer

This block is a 32-bit down-counter that gives a processor core a timed interrupt, either once or at a fixed period. Software programs it through four 32-bit registers. One register holds the period. One holds the live count. One is control, with an enable, a reload mode, an interrupt enable and an 8-bit prescaler. The last is a sticky event flag that software clears by writing a one to it. The counter steps at half the core clock rate, divided further by the prescaler plus one.

The live count can be written on its own, apart from the period register. Software can therefore set the delay to the first event differently from the period used for the events that follow. The count runs down to zero and sets the event flag. On the next step it either reloads from the period register or, in one-shot mode, stops at zero and clears its own enable. The interrupt line is the event flag gated by the interrupt enable.

Top module: `core_event_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Byte offset 0x0 is the period (load) register, 0x4 the live count, 0x8 control and 0xC status. Control bit 0 is enable, bit 1 is auto-reload, bit 2 is interrupt enable and bits 15:8 are the prescaler. Status bit 0 is the event flag. All other bits read zero.
- R3: While enabled, the count decreases by one every 2*(prescaler+1) clock cycles. The first decrement falls on the 2*(prescaler+1)-th rising edge after the edge that writes the enable.
- R4: In auto-reload mode, a step taken at count zero reloads the count from the period register. An expiry therefore occurs every period+1 steps after the first one. The first expiry comes from the directly written count.
- R5: In one-shot mode, the step that brings the count to zero sets the event flag and clears the enable bit. The count then stays at zero.
- R6: The event flag stays set until a write to status with bit 0 high. A write with bit 0 low leaves it unchanged. A new event in the same cycle as a clear leaves the flag set.
- R7: Writing zero to control stops the counter. The count holds its value from then on.
- R8: Writing the period register also copies its value into the count. Writing the count register changes only the count.
- R9: `irq` is high exactly when the event flag and the interrupt enable are both set. It follows a control write in the cycle after that write's edge.
- R10: A one-shot start with the count already at zero sets the flag and disables the timer on the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Timer interrupt request |

## Verification
A prescaler phase that is off by one moves the expiry by whole clock cycles. The bench checks that `irq` is low on the cycle before the expected edge and high on that edge, so such a fault shows within one period. A broken reload or one-shot path shows at the next expiry: the count read back after the reload step differs, or the enable bit still reads set. A wrong flag-clear path shows as an event that never goes away or is lost, read from the status register straight after the write.

// File: rtl/core_event_timer.sv
module core_event_timer #(
  parameter int PSC_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam logic [3:0] A_LOAD = 4'h0;
  localparam logic [3:0] A_CNT  = 4'h4;
  localparam logic [3:0] A_CTRL = 4'h8;
  localparam logic [3:0] A_STAT = 4'hC;
  localparam int PSC_LSB = 8;

  logic [31:0]      load_q, cnt_q;
  logic             en_q, auto_q, ie_q, flag_q, half_q;
  logic [PSC_W-1:0] psc_q, pdiv_q;

  wire wr_load = reg_we && reg_addr == A_LOAD;
  wire wr_cnt  = reg_we && reg_addr == A_CNT;
  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_stat = reg_we && reg_addr == A_STAT;

  wire base_tick = en_q & half_q;
  wire step      = base_tick & (pdiv_q == psc_q);
  wire at_zero   = cnt_q == '0;
  wire hit       = step & ((cnt_q == 32'd1) | (at_zero & ~auto_q));
  wire reload    = step & at_zero & auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      pdiv_q <= '0;
    end else if (!en_q) begin
      half_q <= 1'b0;
      pdiv_q <= '0;
    end else begin
      half_q <= ~half_q;
      if (base_tick) pdiv_q <= step ? '0 : pdiv_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_load) load_q <= reg_wdata;
      if (wr_cnt || wr_load)   cnt_q <= reg_wdata;
      else if (reload)         cnt_q <= load_q;
      else if (step && !at_zero) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
      psc_q  <= '0;
    end else if (wr_ctrl) begin
      en_q   <= reg_wdata[0];
      auto_q <= reg_wdata[1];
      ie_q   <= reg_wdata[2];
      psc_q  <= reg_wdata[PSC_LSB +: PSC_W];
    end else if (hit && !auto_q) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (hit)                     flag_q <= 1'b1;
    else if (wr_stat && reg_wdata[0]) flag_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LOAD: reg_rdata = load_q;
      A_CNT:  reg_rdata = cnt_q;
      A_CTRL: begin
        reg_rdata[PSC_LSB +: PSC_W] = psc_q;
        reg_rdata[2:0] = {ie_q, auto_q, en_q};
      end
      A_STAT: reg_rdata[0] = flag_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = flag_q & ie_q;

  p_tick_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !wr_cnt && !wr_load) |=> cnt_q == $past(cnt_q) - 32'd1);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && auto_q && !wr_cnt && !wr_load) |=> cnt_q == $past(load_q));

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !auto_q && !wr_ctrl) |=> !en_q && flag_q);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_stat && reg_wdata[0])) |=> flag_q);

  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cnt && !wr_load) |=> $stable(cnt_q));
endmodule

// File: tb/core_event_timer_tb_top.sv
`timescale 1ns/1ps
module core_event_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  core_event_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {prescaler, start count, expected cycles to expiry = 2*count*(psc+1)}
  localparam logic [31:0] VEC [5] = '{
    {8'd0, 8'd1, 16'd2},
    {8'd0, 8'd5, 16'd10},
    {8'd3, 8'd2, 16'd16},
    {8'd1, 8'd7, 16'd28},
    {8'd7, 8'd3, 16'd48}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    rd(4'h0, v); check("R1 load", v, 0);
    rd(4'h4, v); check("R1 count", v, 0);
    rd(4'h8, v); check("R1 ctrl", v, 0);
    rd(4'hC, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);

    // R3 vector table: expiry timing versus prescaler
    for (int i = 0; i < 5; i++) begin
      wr(4'h8, 0);
      wr(4'hC, 1);
      wr(4'h4, {24'd0, VEC[i][23:16]});
      wr(4'h8, {16'd0, VEC[i][31:24], 8'h05});
      wait_cyc(int'(VEC[i][15:0]) - 1);
      check("R3 early", irq, 0);
      wait_cyc(1);
      check("R3 expiry", irq, 1);
    end

    // R4 auto-reload with separate first count
    wr(4'h8, 0); wr(4'hC, 1);
    wr(4'h0, 5); wr(4'h4, 3); wr(4'h8, 32'h7);
    wait_cyc(5); check("R4 first early", irq, 0);
    wait_cyc(1); check("R4 first expiry", irq, 1);
    wait_cyc(2); rd(4'h4, v); check("R4 reloaded", v, 5);
    wr(4'hC, 1); check("R6 cleared", irq, 0);
    wait_cyc(8); check("R4 second early", irq, 0);
    wait_cyc(1); check("R4 second expiry", irq, 1);

    // R5 one-shot self-disable
    wr(4'h8, 0); wr(4'hC, 1);
    wr(4'h4, 2); wr(4'h8, 32'h5);
    wait_cyc(3); check("R5 early", irq, 0);
    wait_cyc(1); check("R5 expiry", irq, 1);
    rd(4'h8, v); check("R5 enable cleared", v, 32'h4);
    wait_cyc(10);
    rd(4'h4, v); check("R5 count held", v, 0);

    // R6 write-one-to-clear
    wr(4'hC, 0); rd(4'hC, v); check("R6 zero write ignored", v, 1);
    wr(4'hC, 1); rd(4'hC, v); check("R6 one write clears", v, 0);

    // R10 one-shot from zero
    wr(4'h4, 0); wr(4'h8, 32'h5);
    wait_cyc(1); rd(4'hC, v); check("R10 early", v, 0);
    wait_cyc(1); rd(4'hC, v); check("R10 flag", v, 1);
    rd(4'h8, v); check("R10 disabled", v, 32'h4);

    // R9 interrupt gating
    wr(4'h8, 0); wr(4'hC, 1);
    wr(4'h4, 1); wr(4'h8, 32'h1);
    wait_cyc(2);
    rd(4'hC, v); check("R9 flag without ie", v, 1);
    check("R9 irq masked", irq, 0);
    wr(4'h8, 32'h4); check("R9 irq unmasked", irq, 1);
    wr(4'h8, 0); check("R9 irq masked again", irq, 0);
    rd(4'hC, v); check("R9 flag kept", v, 1);
    wr(4'hC, 1);

    // R7 stop holds count
    wr(4'h4, 100); wr(4'h8, 32'h1);
    wait_cyc(10); rd(4'h4, v); check("R7 running", v, 95);
    wr(4'h8, 0); rd(4'h4, v); check("R7 stopped", v, 95);
    wait_cyc(20); rd(4'h4, v); check("R7 held", v, 95);

    // R8 load copies into count, count write leaves load
    wr(4'h0, 9); rd(4'h4, v); check("R8 load copies", v, 9);
    wr(4'h4, 4); rd(4'h4, v); check("R8 count write", v, 4);
    rd(4'h0, v); check("R8 load kept", v, 9);

    // R2 control field layout
    wr(4'h8, 32'h0000AB06); rd(4'h8, v); check("R2 ctrl fields", v, 32'h0000AB06);
    wr(4'h8, 32'hFFFFFFF8); rd(4'h8, v); check("R2 reserved bits", v, 32'h0000FF00);
    wr(4'h8, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule